// File: doc/BRIEF.md
# Logical Address Match Filter

This block sits behind the bit decoder of a consumer-electronics control bus receiver. When the decoder presents the first byte of a frame, the filter decides whether the frame belongs to this device. It raises an accept flag, and it raises an acknowledge request when the acknowledge waveform generator should answer. Three address slots can be programmed through a small register port. Each slot holds a 4-bit logical address and has its own enable bit. The broadcast destination is always accepted.

The header byte carries the initiator address in its high nibble and the destination in its low nibble. The decision is taken on the header cycle using the configuration as it stood before that clock edge. It is then held until the decoder signals the end of the frame. A configuration write therefore never disturbs a frame already in progress. Writing zero to the enable field switches off all directed reception in a single access.

Top module: `cec_addr_filter`

## Requirements
- R1: After reset the enable field and all slot addresses read zero, and `frm_accept` and `frm_ack_req` are low.
- R2: Register select 0 holds the slot enables in bits [6:4]: bit 4 enables slot 0, bit 5 enables slot 1 and bit 6 enables slot 2. The other bits of select 0 read as zero. Readback on `cfg_rdata` is combinational from the registered values.
- R3: Register select 1 holds slot 0's address in bits [3:0] and slot 1's address in bits [7:4]. Register select 2 holds slot 2's address in bits [3:0], and its bits [7:4] read as zero.
- R4: Select 3 reads zero, and a write to it changes no register.
- R5: The destination is `hdr_byte[3:0]`, and the initiator nibble `hdr_byte[7:4]` has no effect. A destination other than 15 that equals the address of an enabled slot drives both `frm_accept` and `frm_ack_req` high in the cycle after the `hdr_valid` edge.
- R6: An address held in a disabled slot never matches. With bits [6:4] of select 0 all cleared, no destination other than 15 is accepted.
- R7: Destination 15 (broadcast) is always accepted and never raises `frm_ack_req`, even when an enabled slot holds 15.
- R8: The outputs keep their value until `frame_end`, which clears both of them at its edge. When `hdr_valid` and `frame_end` occur in the same cycle, the new header wins.
- R9: A configuration write takes effect only from the next header. A write in the same cycle as `hdr_valid` is not seen by that header, and a write made mid-frame leaves the held outputs unchanged.
- R10: `frm_ack_req` is never high while `frm_accept` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select (0 enables, 1 slots 0/1, 2 slot 2, 3 unused) |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register readback of the selected register |
| hdr_valid | input | 1 | Header byte of a new frame is present |
| hdr_byte | input | 8 | Header byte: initiator [7:4], destination [3:0] |
| frame_end | input | 1 | Current frame has finished |
| frm_accept | output | 1 | Frame is addressed to this device or is broadcast |
| frm_ack_req | output | 1 | Directed frame must be acknowledged |

## Verification
Two pairs of events can fall on the same edge. The first is a register write and a header evaluation. The second is a header and the end of the previous frame. The bench provokes the first by driving `cfg_we` with a mask of zero in the same cycle as a header that matches an enabled slot. It expects acceptance, because the header must see the old enables. For the second pair it raises `hdr_valid` and `frame_end` together and expects the new header's decision to survive. Around these cases, a sweep covers every enable mask, several address patterns and all 256 header bytes. Each expected result is computed arithmetically from the bench's own model of the slots.

// File: rtl/cec_filt_pkg.sv
package cec_filt_pkg;
    localparam int NUM_SLOTS = 3;
    localparam int ADDR_W    = 4;
    localparam int DATA_W    = 8;
    localparam int SEL_W     = 2;
    localparam int EN_LSB    = 4;
    localparam int SLOTS_PER_REG = DATA_W / ADDR_W;
    localparam logic [ADDR_W-1:0] BCAST_ADDR = '1;

    typedef struct packed {
        logic [NUM_SLOTS-1:0]             en;
        logic [NUM_SLOTS-1:0][ADDR_W-1:0] addr;
    } slot_cfg_t;

    typedef struct packed {
        logic accept;
        logic ack;
    } decision_t;
endpackage

// File: rtl/cec_filt_regs.sv
module cec_filt_regs
    import cec_filt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [SEL_W-1:0]  sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output slot_cfg_t         cfg
);
    slot_cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            if (sel == SEL_W'(0)) begin
                cfg_d.en = wdata[EN_LSB +: NUM_SLOTS];
            end
            for (int i = 0; i < NUM_SLOTS; i++) begin
                if (sel == SEL_W'(i / SLOTS_PER_REG + 1)) begin
                    cfg_d.addr[i] = wdata[(i % SLOTS_PER_REG) * ADDR_W +: ADDR_W];
                end
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (sel == SEL_W'(0)) begin
            rdata[EN_LSB +: NUM_SLOTS] = cfg_q.en;
        end
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (sel == SEL_W'(i / SLOTS_PER_REG + 1)) begin
                rdata[(i % SLOTS_PER_REG) * ADDR_W +: ADDR_W] = cfg_q.addr[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg = cfg_q;
endmodule

// File: rtl/cec_filt_match.sv
module cec_filt_match
    import cec_filt_pkg::*;
(
    input  slot_cfg_t         cfg,
    input  logic [ADDR_W-1:0] dest,
    output logic              hit,
    output logic              bcast
);
    logic [NUM_SLOTS-1:0] slot_hit;

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        assign slot_hit[g] = cfg.en[g] && (cfg.addr[g] == dest);
    end

    assign bcast = (dest == BCAST_ADDR);
    assign hit   = |slot_hit;
endmodule

// File: rtl/cec_addr_filter.sv
module cec_addr_filter
    import cec_filt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    input  logic              hdr_valid,
    input  logic [DATA_W-1:0] hdr_byte,
    input  logic              frame_end,
    output logic              frm_accept,
    output logic              frm_ack_req
);
    slot_cfg_t            cfg;
    logic                 hit;
    logic                 bcast;
    logic [NUM_SLOTS-1:0] slot_en;
    decision_t            dec_d, dec_q;

    cec_filt_regs u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .sel   (cfg_sel),
        .wdata (cfg_wdata),
        .rdata (cfg_rdata),
        .cfg   (cfg)
    );

    cec_filt_match u_match (
        .cfg   (cfg),
        .dest  (hdr_byte[ADDR_W-1:0]),
        .hit   (hit),
        .bcast (bcast)
    );

    assign slot_en = cfg.en;

    always_comb begin
        dec_d = dec_q;
        if (hdr_valid) begin
            dec_d.accept = hit || bcast;
            dec_d.ack    = hit && !bcast;
        end else if (frame_end) begin
            dec_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dec_q <= '0;
        else        dec_q <= dec_d;
    end

    assign frm_accept  = dec_q.accept;
    assign frm_ack_req = dec_q.ack;
endmodule

// File: rtl/cec_filt_chk.sv
module cec_filt_chk
    import cec_filt_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic [SEL_W-1:0]     cfg_sel,
    input logic [DATA_W-1:0]    cfg_rdata,
    input logic                 hdr_valid,
    input logic [DATA_W-1:0]    hdr_byte,
    input logic                 frame_end,
    input logic                 frm_accept,
    input logic                 frm_ack_req,
    input logic [NUM_SLOTS-1:0] en
);
    a_r10_ack_needs_accept: assert property (@(posedge clk) disable iff (!rst_n)
        frm_ack_req |-> frm_accept);

    a_r8_hold_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (!hdr_valid && !frame_end) |=> ($stable(frm_accept) && $stable(frm_ack_req)));

    a_r8_clear_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && !hdr_valid) |=> (!frm_accept && !frm_ack_req));

    a_r7_bcast_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && hdr_byte[ADDR_W-1:0] == BCAST_ADDR) |=> (frm_accept && !frm_ack_req));

    a_r6_all_off_rejects: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && en == '0 && hdr_byte[ADDR_W-1:0] != BCAST_ADDR) |=> !frm_accept);

    a_r4_unused_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_sel == SEL_W'(3)) |-> (cfg_rdata == '0));
endmodule

bind cec_addr_filter cec_filt_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_sel     (cfg_sel),
    .cfg_rdata   (cfg_rdata),
    .hdr_valid   (hdr_valid),
    .hdr_byte    (hdr_byte),
    .frame_end   (frame_end),
    .frm_accept  (frm_accept),
    .frm_ack_req (frm_ack_req),
    .en          (slot_en)
);

// File: tb/sim_cec_addr_filter.sv
module sim_cec_addr_filter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_sel = 2'd0;
    logic [7:0] cfg_wdata = 8'd0;
    logic [7:0] cfg_rdata;
    logic       hdr_valid = 1'b0;
    logic [7:0] hdr_byte = 8'd0;
    logic       frame_end = 1'b0;
    logic       frm_accept;
    logic       frm_ack_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [2:0] m_en;
    logic [3:0] m_addr [3];

    always #2 clk = ~clk;

    cec_addr_filter u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .hdr_valid(hdr_valid),
        .hdr_byte(hdr_byte), .frame_end(frame_end), .frm_accept(frm_accept),
        .frm_ack_req(frm_ack_req)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [1:0] s, input logic [7:0] exp);
        @(negedge clk);
        cfg_sel = s;
        #1;
        check(req, cfg_rdata, exp);
    endtask

    task automatic header(input logic [7:0] b);
        @(negedge clk);
        hdr_valid = 1'b1; hdr_byte = b;
        @(negedge clk);
        hdr_valid = 1'b0;
    endtask

    task automatic end_frame();
        @(negedge clk);
        frame_end = 1'b1;
        @(negedge clk);
        frame_end = 1'b0;
    endtask

    function automatic logic [1:0] expect_dec(input logic [3:0] d);
        logic hit;
        hit = 1'b0;
        for (int i = 0; i < 3; i++) if (m_en[i] && m_addr[i] == d) hit = 1'b1;
        if (d == 4'hF) return 2'b10;
        return {hit, hit};
    endfunction

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1 accept", {7'd0, frm_accept}, 8'd0);
        check("R1 ack", {7'd0, frm_ack_req}, 8'd0);
        rd_check("R1 sel0", 2'd0, 8'h00);
        rd_check("R1 sel1", 2'd1, 8'h00);
        rd_check("R1 sel2", 2'd2, 8'h00);

        // Sweep R2 R3 R5 R6 R7 R10: every mask, all headers
        for (int m = 0; m < 8; m++) begin
            m_en = m[2:0];
            m_addr[0] = 4'((m * 5) % 16);
            m_addr[1] = 4'((m * 5 + 3) % 16);
            m_addr[2] = (m == 7) ? 4'hF : 4'((m * 3 + 9) % 16);
            wr(2'd0, {1'b1, m_en, 4'hF});
            wr(2'd1, {m_addr[1], m_addr[0]});
            wr(2'd2, {4'hA, m_addr[2]});
            rd_check("R2 enable field", 2'd0, {1'b0, m_en, 4'h0});
            rd_check("R3 slot0/1", 2'd1, {m_addr[1], m_addr[0]});
            rd_check("R3 slot2", 2'd2, {4'h0, m_addr[2]});
            for (int b = 0; b < 256; b++) begin
                logic [1:0] e;
                e = expect_dec(b[3:0]);
                header(b[7:0]);
                check((b[3:0] == 4'hF) ? "R7 broadcast" : (m == 0 ? "R6 all off" : "R5 match"),
                      {6'd0, frm_accept, frm_ack_req}, {6'd0, e});
                end_frame();
                check("R8 cleared", {6'd0, frm_accept, frm_ack_req}, 8'd0);
            end
        end

        // R4 select 3
        wr(2'd3, 8'hFF);
        rd_check("R4 sel3 reads zero", 2'd3, 8'h00);
        rd_check("R4 sel0 unchanged", 2'd0, 8'h70);
        rd_check("R4 sel1 unchanged", 2'd1, {m_addr[1], m_addr[0]});

        // R9 mid-frame write
        wr(2'd0, 8'h10);
        wr(2'd1, 8'h04);
        header(8'h34);
        check("R9 before write", {6'd0, frm_accept, frm_ack_req}, 8'h03);
        wr(2'd0, 8'h00);
        check("R9 held after write", {6'd0, frm_accept, frm_ack_req}, 8'h03);
        repeat (3) @(negedge clk);
        check("R8 held", {6'd0, frm_accept, frm_ack_req}, 8'h03);
        end_frame();
        header(8'h34);
        check("R6 disabled next frame", {6'd0, frm_accept, frm_ack_req}, 8'h00);
        end_frame();

        // R9 write in same cycle as header
        wr(2'd0, 8'h10);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 2'd0; cfg_wdata = 8'h00;
        hdr_valid = 1'b1; hdr_byte = 8'hE4;
        @(negedge clk);
        cfg_we = 1'b0; hdr_valid = 1'b0;
        check("R9 same-cycle write unseen", {6'd0, frm_accept, frm_ack_req}, 8'h03);
        rd_check("R9 write landed", 2'd0, 8'h00);

        // R8 header and frame_end in same cycle
        wr(2'd0, 8'h10);
        @(negedge clk);
        hdr_valid = 1'b1; frame_end = 1'b1; hdr_byte = 8'h04;
        @(negedge clk);
        hdr_valid = 1'b0; frame_end = 1'b0;
        check("R8 header wins", {6'd0, frm_accept, frm_ack_req}, 8'h03);
        end_frame();
        check("R10 cleared", {6'd0, frm_accept, frm_ack_req}, 8'h00);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule